// File: doc/BRIEF.md
# Freezable Circular Spy Buffer

This block taps a 32-bit data lane that carries a 4-bit K-character flag next to each word. Every valid word that is not an idle filler is stored in a circular dual-port memory. One port belongs to the lane and writes a new word on each accepted cycle. The other port belongs to a host register interface, which reads the stored words at any time without disturbing capture. Because the memory wraps, it always holds the most recent history of the lane, and a sticky overflow flag shows that older words were overwritten.

A global freeze input stops all writes, so the captured history survives until the host has read it. The block also produces its own freeze request, which the board combines with requests from other monitors. The request is raised when a local error input is seen. It is also raised when an end-of-event word passes with its freeze-request bit set, so the freeze takes effect once that event has been recorded.

The host sees a 16-bit status word with three fields: the next free slot, the overflow flag and the freeze flag. Writing to the status address is a clear command that restarts the buffer.

Top module: `spy_trace_buffer`

## Requirements
- R1: A word with `in_valid`=1 and `in_kflag` other than 4'b1111 is written at the current pointer when `freeze_in`=0. The pointer then advances by one on that clock edge.
- R2: Words with `in_kflag`=4'b1111 (idle) and cycles with `in_valid`=0 are not stored and do not move the pointer.
- R3: While `freeze_in`=1, nothing is written and the pointer holds. The freeze flag sets and stays set until a clear is performed with `freeze_in`=0.
- R4: Writing the top address wraps the pointer to 0 and sets the overflow flag. The flag stays set until a clear, and later words overwrite the oldest entries.
- R5: A host read with `host_sel_status`=1 returns the status word on `host_rdata` in the cycle after the read edge. The status word holds the pointer zero-extended in bits 12:0, zero in bit 13, overflow in bit 14, freeze in bit 15, and zero in bits 31:16. `host_rvalid` is high exactly in the cycle after `host_rd`. After reset the status word is 0.
- R6: `host_wr`=1 with `host_sel_status`=1 is a clear. It sets the pointer to 0, clears overflow, clears the freeze request, and loads the freeze flag with the current `freeze_in`. A lane word that arrives in the same cycle is dropped.
- R7: `host_wr`=1 with `host_sel_status`=0 has no effect on the memory, the status word or the freeze request.
- R8: `err_in`=1 sets `freeze_req` on the next edge. `freeze_req` stays high until a clear. A set that arrives in the same cycle as a clear wins.
- R9: An end-of-event word (`in_data[31:24]`=8'hF7 and `in_kflag`=4'b1000) with `in_data[23]`=1 sets `freeze_req` on the next edge and is itself stored. With bit 23 at 0, or with any other K flag, no request is raised.
- R10: A host read with `host_sel_status`=0 returns, in the cycle after the read edge, the stored data on `host_rdata` and its K flag on `host_rkflag` for address `host_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for lane and host |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Lane word valid |
| in_data | input | 32 | Lane data word |
| in_kflag | input | 4 | K-character flag of the lane word |
| err_in | input | 1 | Local error indication |
| freeze_in | input | 1 | Global freeze; blocks all writes |
| freeze_req | output | 1 | Sticky freeze request to the board |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe (a clear when the status is selected) |
| host_sel_status | input | 1 | 1 selects the status word, 0 selects the memory |
| host_addr | input | ADDR_W | Memory address for host reads |
| host_rdata | output | 32 | Read data, one cycle after the read edge |
| host_rkflag | output | 4 | K flag of the word read from memory |
| host_rvalid | output | 1 | Read data valid |

## Verification
The checker tests the pointer on every cycle. It must advance on an accepted word, hold on idle words, invalid cycles and frozen cycles, and wrap with overflow set at the top address. It also checks that a clear empties the pointer, that the freeze flag follows the freeze input, that an error or a flagged end-of-event word raises the request, and that the read strobe produces read-valid one cycle later. The bench scenarios cover what needs stored history: data and K flags read back from every slot after a wrap, memory contents that stay unchanged while frozen or after a host write to the memory space, and a freeze flag that outlives the freeze until the next clear.

// File: rtl/spy_pkg.sv
package spy_pkg;

    localparam int WORD_W     = 32;
    localparam int KF_W       = 4;
    localparam int STAT_PTR_W = 13;
    localparam int STAT_W     = 16;

    localparam logic [KF_W-1:0] KF_IDLE  = 4'b1111;
    localparam logic [KF_W-1:0] KF_EOE   = 4'b1000;
    localparam logic [7:0]      EOE_TAG  = 8'hF7;
    localparam int              FRZ_BIT  = 23;

    typedef struct packed {
        logic [KF_W-1:0]   kf;
        logic [WORD_W-1:0] data;
    } lane_word_t;

    typedef struct packed {
        logic                  frozen;
        logic                  wrapped;
        logic                  rsvd;
        logic [STAT_PTR_W-1:0] ptr;
    } spy_status_t;

    function automatic logic word_is_idle(lane_word_t w);
        return w.kf == KF_IDLE;
    endfunction

    function automatic logic word_asks_freeze(lane_word_t w);
        return (w.kf == KF_EOE) && (w.data[WORD_W-1 -: 8] == EOE_TAG) && w.data[FRZ_BIT];
    endfunction

endpackage

// File: rtl/spy_word_classify.sv
module spy_word_classify
    import spy_pkg::*;
(
    input  logic       valid,
    input  lane_word_t word,
    output logic       keep,
    output logic       eoe_freeze
);
    always_comb begin
        keep       = valid && !word_is_idle(word);
        eoe_freeze = valid && word_asks_freeze(word);
    end
endmodule

// File: rtl/spy_ring_ctrl.sv
module spy_ring_ctrl
    import spy_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              keep,
    input  logic              eoe_freeze,
    input  logic              err_in,
    input  logic              freeze_in,
    input  logic              clr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output spy_status_t       status,
    output logic              freeze_req
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
    localparam int                PAD_W    = STAT_PTR_W - ADDR_W;

    logic [ADDR_W-1:0] ptr_q;
    logic              wrapped_q;
    logic              frozen_q;
    logic              req_q;

    assign wr_en   = keep && !freeze_in && !clr;
    assign wr_addr = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q     <= '0;
            wrapped_q <= 1'b0;
            frozen_q  <= 1'b0;
            req_q     <= 1'b0;
        end else begin
            if (clr) begin
                ptr_q     <= '0;
                wrapped_q <= 1'b0;
                frozen_q  <= freeze_in;
            end else begin
                frozen_q <= frozen_q | freeze_in;
                if (wr_en) begin
                    ptr_q <= ptr_q + 1'b1;
                    if (ptr_q == TOP_ADDR) begin
                        wrapped_q <= 1'b1;
                    end
                end
            end
            req_q <= (req_q && !clr) || err_in || eoe_freeze;
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign status.ptr = {{PAD_W{1'b0}}, ptr_q};
        end else begin : g_full
            assign status.ptr = ptr_q[STAT_PTR_W-1:0];
        end
    endgenerate

    assign status.rsvd    = 1'b0;
    assign status.wrapped = wrapped_q;
    assign status.frozen  = frozen_q;
    assign freeze_req     = req_q;
endmodule

// File: rtl/spy_dpram.sv
module spy_dpram
    import spy_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              a_en,
    input  logic [ADDR_W-1:0] a_addr,
    input  lane_word_t        a_word,
    input  logic              b_en,
    input  logic [ADDR_W-1:0] b_addr,
    output lane_word_t        b_word
);
    localparam int DEPTH = 1 << ADDR_W;

    lane_word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (a_en) begin
            mem[a_addr] <= a_word;
        end
    end

    always_ff @(posedge clk) begin
        if (b_en) begin
            b_word <= mem[b_addr];
        end
    end
endmodule

// File: rtl/spy_host_port.sv
module spy_host_port
    import spy_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic              sel_status,
    input  spy_status_t       status,
    input  lane_word_t        mem_word,
    output logic [WORD_W-1:0] rdata,
    output logic [KF_W-1:0]   rkflag,
    output logic              rvalid
);
    logic        rvalid_q;
    logic        sel_q;
    spy_status_t stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            sel_q    <= 1'b0;
            stat_q   <= '0;
        end else begin
            rvalid_q <= rd;
            if (rd) begin
                sel_q  <= sel_status;
                stat_q <= status;
            end
        end
    end

    always_comb begin
        if (sel_q) begin
            rdata  = {{(WORD_W-STAT_W){1'b0}}, stat_q};
            rkflag = '0;
        end else begin
            rdata  = mem_word.data;
            rkflag = mem_word.kf;
        end
    end

    assign rvalid = rvalid_q;
endmodule

// File: rtl/spy_trace_buffer.sv
module spy_trace_buffer
    import spy_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       in_data,
    input  logic [3:0]        in_kflag,
    input  logic              err_in,
    input  logic              freeze_in,
    output logic              freeze_req,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic              host_sel_status,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [31:0]       host_rdata,
    output logic [3:0]        host_rkflag,
    output logic              host_rvalid
);
    lane_word_t        lane_w;
    lane_word_t        mem_q;
    spy_status_t       stat_w;
    logic              keep_w;
    logic              eoe_frz_w;
    logic              clr_w;
    logic              wr_en_w;
    logic [ADDR_W-1:0] wr_addr_w;

    assign lane_w.data = in_data;
    assign lane_w.kf   = in_kflag;
    assign clr_w       = host_wr && host_sel_status;

    spy_word_classify u_classify (
        .valid      (in_valid),
        .word       (lane_w),
        .keep       (keep_w),
        .eoe_freeze (eoe_frz_w)
    );

    spy_ring_ctrl #(.ADDR_W(ADDR_W)) u_ring (
        .clk        (clk),
        .rst        (rst),
        .keep       (keep_w),
        .eoe_freeze (eoe_frz_w),
        .err_in     (err_in),
        .freeze_in  (freeze_in),
        .clr        (clr_w),
        .wr_en      (wr_en_w),
        .wr_addr    (wr_addr_w),
        .status     (stat_w),
        .freeze_req (freeze_req)
    );

    spy_dpram #(.ADDR_W(ADDR_W)) u_mem (
        .clk    (clk),
        .a_en   (wr_en_w),
        .a_addr (wr_addr_w),
        .a_word (lane_w),
        .b_en   (host_rd),
        .b_addr (host_addr),
        .b_word (mem_q)
    );

    spy_host_port u_host (
        .clk        (clk),
        .rst        (rst),
        .rd         (host_rd),
        .sel_status (host_sel_status),
        .status     (stat_w),
        .mem_word   (mem_q),
        .rdata      (host_rdata),
        .rkflag     (host_rkflag),
        .rvalid     (host_rvalid)
    );
endmodule

// File: rtl/spy_trace_buffer_chk.sv
module spy_trace_buffer_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [31:0]       in_data,
    input logic [3:0]        in_kflag,
    input logic              err_in,
    input logic              freeze_in,
    input logic              freeze_req,
    input logic              host_rd,
    input logic              host_wr,
    input logic              host_sel_status,
    input logic              host_rvalid,
    input logic [15:0]       st
);
    logic              clr;
    logic              accept;
    logic [ADDR_W-1:0] ptr_w;

    assign clr    = host_wr && host_sel_status;
    assign accept = in_valid && (in_kflag != 4'b1111) && !freeze_in && !clr;
    assign ptr_w  = st[ADDR_W-1:0];

    a_r1_advance: assert property (@(posedge clk) disable iff (rst)
        accept |=> ptr_w == ADDR_W'($past(ptr_w) + 1'b1));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        ((!in_valid || in_kflag == 4'b1111) && !clr) |=> $stable(ptr_w));

    a_r3_frozen_hold: assert property (@(posedge clk) disable iff (rst)
        (freeze_in && !clr) |=> ($stable(ptr_w) && st[15]));

    a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
        (accept && ptr_w == {ADDR_W{1'b1}}) |=> (ptr_w == '0 && st[14]));

    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (ptr_w == '0 && !st[14]));

    a_r8_err_request: assert property (@(posedge clk) disable iff (rst)
        err_in |=> freeze_req);

    a_r9_eoe_request: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kflag == 4'b1000 && in_data[31:24] == 8'hF7 && in_data[23]) |=> freeze_req);

    a_r5_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
        host_rd |=> host_rvalid);

    a_r5_rvalid_idle: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> !host_rvalid);
endmodule

bind spy_trace_buffer spy_trace_buffer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .in_valid        (in_valid),
    .in_data         (in_data),
    .in_kflag        (in_kflag),
    .err_in          (err_in),
    .freeze_in       (freeze_in),
    .freeze_req      (freeze_req),
    .host_rd         (host_rd),
    .host_wr         (host_wr),
    .host_sel_status (host_sel_status),
    .host_rvalid     (host_rvalid),
    .st              (stat_w)
);

// File: tb/spy_trace_buffer_test.sv
module spy_trace_buffer_test;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [31:0]   in_data = '0;
    logic [3:0]    in_kflag = '0;
    logic          err_in = 1'b0;
    logic          freeze_in = 1'b0;
    logic          freeze_req;
    logic          host_rd = 1'b0;
    logic          host_wr = 1'b0;
    logic          host_sel_status = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0]   host_rdata;
    logic [3:0]    host_rkflag;
    logic          host_rvalid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] m_d   [DEPTH];
    logic [3:0]  m_k   [DEPTH];
    bit          m_ok  [DEPTH];
    int          m_ptr = 0;
    bit          m_ovf = 0;
    bit          m_frz = 0;
    bit          m_req = 0;
    bit          frz_level = 0;

    always #5 clk = ~clk;

    spy_trace_buffer #(.ADDR_W(AW)) uut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        return {16'h0, m_frz, m_ovf, 1'b0, 13'(m_ptr)};
    endfunction

    task automatic cycle(input logic v, input logic [31:0] d, input logic [3:0] k, input logic e,
                         input logic w, input logic s, input logic r, input logic [AW-1:0] a);
        bit clr;
        in_valid = v; in_data = d; in_kflag = k; err_in = e;
        host_wr = w; host_sel_status = s; host_rd = r; host_addr = a; freeze_in = frz_level;
        @(posedge clk);
        clr = w && s;
        if (clr) begin
            m_ptr = 0; m_ovf = 0; m_frz = frz_level;
        end else begin
            m_frz = m_frz | frz_level;
            if (v && k != 4'hF && !frz_level) begin
                m_d[m_ptr] = d; m_k[m_ptr] = k; m_ok[m_ptr] = 1;
                if (m_ptr == DEPTH-1) m_ovf = 1;
                m_ptr = (m_ptr + 1) % DEPTH;
            end
        end
        m_req = (m_req && !clr) || e || (v && k == 4'b1000 && d[31:24] == 8'hF7 && d[23]);
        @(negedge clk);
        in_valid = 0; err_in = 0; host_wr = 0; host_rd = 0;
    endtask

    task automatic push(input logic [31:0] d, input logic [3:0] k);
        cycle(1'b1, d, k, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic idle();
        cycle(1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic clear();
        cycle(1'b0, 32'h0, 4'h0, 1'b0, 1'b1, 1'b1, 1'b0, '0);
    endtask

    task automatic check_status(input string tag);
        cycle(1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b1, '0);
        chk(tag, {32'h0, host_rdata}, {32'h0, exp_status()});
    endtask

    task automatic sweep_mem(input string tag);
        for (int a = 0; a < DEPTH; a++) begin
            if (m_ok[a]) begin
                cycle(1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, AW'(a));
                chk(tag, {28'h0, host_rkflag, host_rdata}, {28'h0, m_k[a], m_d[a]});
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) m_ok[a] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R5: reset state
        chk("R5 rvalid after reset", {63'h0, host_rvalid}, 64'h0);
        chk("R8 freeze_req after reset", {63'h0, freeze_req}, 64'h0);
        check_status("R5 status after reset");
        chk("R5 rvalid after read", {63'h0, host_rvalid}, 64'h1);
        idle();
        chk("R5 rvalid drops", {63'h0, host_rvalid}, 64'h0);

        // R1 / R2: store words, with idle words and invalid cycles mixed in
        for (int i = 0; i < 12; i++) begin
            push(32'hA000_0000 + 32'(i * 3 + 1), 4'(i % 3));
            push(32'hBCBC_1C1C, 4'hF);
            if (i % 4 == 0) idle();
        end
        check_status("R1 pointer after 12 words");
        for (int i = 0; i < 5; i++) push(32'h1234_5678, 4'hF);
        check_status("R2 idle words ignored");
        sweep_mem("R10 readback");

        // R4: wrap past the top address
        for (int i = 0; i < 6; i++) push(32'hC000_0000 + 32'(i * 7), 4'(i + 4));
        check_status("R4 wrap and overflow");
        sweep_mem("R4 oldest overwritten");

        // R7: host write to memory space has no effect
        cycle(1'b0, 32'h0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, AW'(3));
        check_status("R7 status unchanged");
        sweep_mem("R7 memory unchanged");

        // R3: freeze blocks writes
        frz_level = 1;
        for (int i = 0; i < 5; i++) push(32'hDEAD_0000 + 32'(i), 4'h0);
        check_status("R3 pointer held, freeze flag set");
        sweep_mem("R3 memory kept");
        clear();
        check_status("R6 clear while frozen keeps freeze flag");
        frz_level = 0;
        idle();
        check_status("R3 freeze flag sticky after release");
        clear();
        check_status("R6 clear after release");

        // R6: word in the clear cycle is dropped
        push(32'h0101_0101, 4'h1);
        cycle(1'b1, 32'h0202_0202, 4'h2, 1'b0, 1'b1, 1'b1, 1'b0, '0);
        check_status("R6 concurrent word dropped");

        // R8: error request, sticky until clear
        cycle(1'b0, 32'h0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        chk("R8 request raised", {63'h0, freeze_req}, {63'h0, m_req});
        idle(); idle();
        chk("R8 request sticky", {63'h0, freeze_req}, 64'h1);
        cycle(1'b0, 32'h0, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0, '0);
        chk("R8 set wins over clear", {63'h0, freeze_req}, 64'h1);
        clear();
        chk("R8 request cleared", {63'h0, freeze_req}, 64'h0);

        // R9: end-of-event freeze bit
        push(32'hF780_0001, 4'b0000);
        chk("R9 wrong K flag no request", {63'h0, freeze_req}, 64'h0);
        push(32'hF700_0002, 4'b1000);
        chk("R9 bit23 clear no request", {63'h0, freeze_req}, 64'h0);
        push(32'hF780_0003, 4'b1000);
        chk("R9 flagged end-of-event request", {63'h0, freeze_req}, 64'h1);
        check_status("R9 end-of-event word stored");
        sweep_mem("R9 readback");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule